// File: doc/BRIEF.md
# CPU Single-Step Clock Controller

This block sits between a debug command stream and an attached 8-bit microprocessor. It produces the processor's two-phase clock (a single PHI2 line) and its active-low reset, and it holds the processor's other control inputs at their idle levels. It gates the clock according to byte commands that arrive on a valid/ready stream. In step mode the clock is parked low and each step byte releases exactly one clock cycle. In run mode cycles follow each other without stopping. A reset byte replays the power-up reset sequence.

Each processor cycle has a high phase and a low phase, each `PHASE_LEN` system clocks long. The block samples the processor's address, data and status outputs in the last system clock of the high phase. When PHI2 falls, it can publish them as a one-clock trace record. Records are always produced for stepped cycles. During free running they appear only for cycles that end while a command byte is waiting. Cycles issued during a reset sequence produce no record.

Top module: `cpu_stepclk`

## Requirements
- R1: After `rstN` is released, and after every accepted reset byte (0x72), `cpuResN` stays low for exactly 2 complete clock cycles. It then goes high while PHI2 is low, and 7 more complete cycles follow before the controller returns to its mode. No trace record is produced during this sequence.
- R2: `cpuRdy`, `cpuIrqN`, `cpuNmiN`, `cpuSoN` and `cpuBusEn` are driven high at all times.
- R3: When the power-up sequence ends the controller is in step mode. PHI2 then stays low until a step byte is accepted.
- R4: In step mode an accepted step byte (0x73) produces exactly one cycle. PHI2 goes high on the accepting edge, stays high for `PHASE_LEN` clocks and stays low for `PHASE_LEN` clocks. Only after that is the next command taken.
- R5: In step mode an accepted continue byte (0x63) selects run mode. Cycles then repeat back to back, with one idle low clock between cycles.
- R6: In run mode an accepted break byte (0x62) selects step mode. The clock stays parked low after the cycle that had already finished.
- R7: A reset byte (0x72) accepted in either mode runs the R1 sequence. The controller then resumes the mode it was in.
- R8: Any byte that does not apply in the current mode is consumed without effect. This covers break in step mode, step or continue in run mode, and any other value. The clock and the mode continue exactly as before.
- R9: A trace record is a one-clock `traceValid` pulse on the clock after PHI2 falls. It carries the address, data and flags present on the last high-phase clock. The flags are: bit 0 read/write (1 = read), bit 1 opcode-fetch sync, bit 2 memory-lock (active low), bit 3 vector-pull (active low).
- R10: A stepped cycle always yields a trace record. A free-running cycle yields one only when `cmdValid` is high on the clock where PHI2 falls.
- R11: `cmdReady` is high only in step or run mode, while no cycle is in progress and PHI2 is low. It is never high while `cpuResN` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low system reset |
| cmdValid | input | 1 | Command byte present |
| cmdData | input | 8 | Command byte |
| cmdReady | output | 1 | Command byte taken on this edge when valid |
| cpuPhi2 | output | 1 | Processor clock |
| cpuResN | output | 1 | Processor reset, active low |
| cpuRdy | output | 1 | Processor ready input, held high |
| cpuIrqN | output | 1 | Processor interrupt request, held high |
| cpuNmiN | output | 1 | Processor non-maskable interrupt, held high |
| cpuSoN | output | 1 | Processor set-overflow input, held high |
| cpuBusEn | output | 1 | Processor bus enable, held high |
| cpuRw | input | 1 | Processor read/write status |
| cpuSync | input | 1 | Processor opcode-fetch status |
| cpuMemLockN | input | 1 | Processor memory-lock status, active low |
| cpuVecPullN | input | 1 | Processor vector-pull status, active low |
| cpuAddr | input | 16 | Processor address bus |
| cpuData | input | 8 | Processor data bus |
| traceValid | output | 1 | One-clock trace record strobe |
| traceFlags | output | 4 | Captured status flags (layout in R9) |
| traceAddr | output | 16 | Captured address |
| traceData | output | 8 | Captured data |

## Verification
The assertions assume that `rstN` is asserted only at the start of a run. They also assume that a command byte, once offered, stays on `cmdData` with `cmdValid` high until the edge where `cmdReady` takes it. The bench's command task holds each byte in that way. Run-mode tracing depends on how long a byte waits, so the bench offers bytes while cycles are in flight and compares against a behavioural model every clock. The processor bus is driven with a new value on every clock, so any capture taken on the wrong clock shows up as a mismatch.

// File: rtl/cpu_stepclk_pkg.sv
package cpu_stepclk_pkg;

  typedef enum logic [1:0] {
    SEQ_RESLO = 2'd0,
    SEQ_RESHI = 2'd1,
    SEQ_STEP  = 2'd2,
    SEQ_RUN   = 2'd3
  } seqState_t;

  typedef enum logic [1:0] {
    TRC_NONE    = 2'd0,
    TRC_ALWAYS  = 2'd1,
    TRC_IFQUEUE = 2'd2
  } traceKind_t;

  typedef struct packed {
    logic       start;
    traceKind_t kind;
  } clkStrobe_t;

  localparam logic [7:0] OP_STEP  = 8'h73;
  localparam logic [7:0] OP_CONT  = 8'h63;
  localparam logic [7:0] OP_BREAK = 8'h62;
  localparam logic [7:0] OP_RESET = 8'h72;

endpackage

// File: rtl/cpu_stepclk_ctrl.sv
module cpu_stepclk_ctrl
  import cpu_stepclk_pkg::*;
#(
  parameter int RES_LO_CYC = 2,
  parameter int RES_HI_CYC = 7
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       genIdle,
  input  logic       cmdValid,
  input  logic [7:0] cmdData,
  output logic       cmdReady,
  output logic       cpuResN,
  output clkStrobe_t strobe
);

  localparam int CNT_MAX = (RES_LO_CYC > RES_HI_CYC) ? RES_LO_CYC : RES_HI_CYC;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  seqState_t        state, stateNxt;
  logic [CNT_W-1:0] cycCnt, cycCntNxt;
  logic             resumeRun, resumeRunNxt;
  logic             accept;

  assign cmdReady = genIdle && ((state == SEQ_STEP) || (state == SEQ_RUN));
  assign accept   = cmdReady && cmdValid;
  assign cpuResN  = (state != SEQ_RESLO);

  always_comb begin
    stateNxt     = state;
    cycCntNxt    = cycCnt;
    resumeRunNxt = resumeRun;
    strobe       = '{start: 1'b0, kind: TRC_NONE};
    unique case (state)
      SEQ_RESLO: begin
        if (genIdle) begin
          if (cycCnt == CNT_W'(RES_LO_CYC)) begin
            stateNxt  = SEQ_RESHI;
            cycCntNxt = '0;
          end else begin
            strobe.start = 1'b1;
            cycCntNxt    = cycCnt + 1'b1;
          end
        end
      end
      SEQ_RESHI: begin
        if (genIdle) begin
          if (cycCnt == CNT_W'(RES_HI_CYC)) begin
            stateNxt  = resumeRun ? SEQ_RUN : SEQ_STEP;
            cycCntNxt = '0;
          end else begin
            strobe.start = 1'b1;
            cycCntNxt    = cycCnt + 1'b1;
          end
        end
      end
      SEQ_STEP: begin
        if (accept) begin
          case (cmdData)
            OP_STEP: begin
              strobe.start = 1'b1;
              strobe.kind  = TRC_ALWAYS;
            end
            OP_CONT:  stateNxt = SEQ_RUN;
            OP_RESET: begin
              stateNxt     = SEQ_RESLO;
              cycCntNxt    = '0;
              resumeRunNxt = 1'b0;
            end
            default: ;
          endcase
        end
      end
      SEQ_RUN: begin
        if (genIdle) begin
          if (cmdValid) begin
            case (cmdData)
              OP_BREAK: stateNxt = SEQ_STEP;
              OP_RESET: begin
                stateNxt     = SEQ_RESLO;
                cycCntNxt    = '0;
                resumeRunNxt = 1'b1;
              end
              default: ;
            endcase
          end else begin
            strobe.start = 1'b1;
            strobe.kind  = TRC_IFQUEUE;
          end
        end
      end
      default: stateNxt = SEQ_RESLO;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= SEQ_RESLO;
      cycCnt    <= '0;
      resumeRun <= 1'b0;
    end else begin
      state     <= stateNxt;
      cycCnt    <= cycCntNxt;
      resumeRun <= resumeRunNxt;
    end
  end

endmodule

// File: rtl/cpu_stepclk_datapath.sv
module cpu_stepclk_datapath
  import cpu_stepclk_pkg::*;
#(
  parameter int PHASE_LEN = 2,
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int FLAG_W    = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  clkStrobe_t        strobe,
  input  logic              cmdValid,
  input  logic [FLAG_W-1:0] busFlags,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busData,
  output logic              phi2,
  output logic              genIdle,
  output logic              traceValid,
  output logic [FLAG_W-1:0] traceFlags,
  output logic [ADDR_W-1:0] traceAddr,
  output logic [DATA_W-1:0] traceData
);

  localparam int PH_W = (PHASE_LEN > 1) ? $clog2(PHASE_LEN) : 1;
  localparam logic [PH_W-1:0] PH_RELOAD = PH_W'(PHASE_LEN - 1);

  logic            busy;
  logic [PH_W-1:0] phCnt;
  traceKind_t      curKind;
  logic            phaseEnd;
  logic            fallNow;
  logic            emitNow;

  assign genIdle  = !busy;
  assign phaseEnd = (phCnt == '0);
  assign fallNow  = busy && phi2 && phaseEnd;
  assign emitNow  = fallNow &&
                    ((curKind == TRC_ALWAYS) || ((curKind == TRC_IFQUEUE) && cmdValid));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      phi2    <= 1'b0;
      phCnt   <= '0;
      curKind <= TRC_NONE;
    end else if (strobe.start) begin
      busy    <= 1'b1;
      phi2    <= 1'b1;
      phCnt   <= PH_RELOAD;
      curKind <= strobe.kind;
    end else if (busy) begin
      if (!phaseEnd) begin
        phCnt <= phCnt - 1'b1;
      end else if (phi2) begin
        phi2  <= 1'b0;
        phCnt <= PH_RELOAD;
      end else begin
        busy <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      traceValid <= 1'b0;
      traceFlags <= '0;
      traceAddr  <= '0;
      traceData  <= '0;
    end else begin
      traceValid <= emitNow;
      if (emitNow) begin
        traceFlags <= busFlags;
        traceAddr  <= busAddr;
        traceData  <= busData;
      end
    end
  end

endmodule

// File: rtl/cpu_stepclk.sv
module cpu_stepclk
  import cpu_stepclk_pkg::*;
#(
  parameter int PHASE_LEN  = 2,
  parameter int RES_LO_CYC = 2,
  parameter int RES_HI_CYC = 7
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdValid,
  input  logic [7:0]  cmdData,
  output logic        cmdReady,
  output logic        cpuPhi2,
  output logic        cpuResN,
  output logic        cpuRdy,
  output logic        cpuIrqN,
  output logic        cpuNmiN,
  output logic        cpuSoN,
  output logic        cpuBusEn,
  input  logic        cpuRw,
  input  logic        cpuSync,
  input  logic        cpuMemLockN,
  input  logic        cpuVecPullN,
  input  logic [15:0] cpuAddr,
  input  logic [7:0]  cpuData,
  output logic        traceValid,
  output logic [3:0]  traceFlags,
  output logic [15:0] traceAddr,
  output logic [7:0]  traceData
);

  clkStrobe_t strobe;
  logic       genIdle;

  assign cpuRdy   = 1'b1;
  assign cpuIrqN  = 1'b1;
  assign cpuNmiN  = 1'b1;
  assign cpuSoN   = 1'b1;
  assign cpuBusEn = 1'b1;

  cpu_stepclk_ctrl #(
    .RES_LO_CYC(RES_LO_CYC),
    .RES_HI_CYC(RES_HI_CYC)
  ) ctrlI (
    .clk     (clk),
    .rstN    (rstN),
    .genIdle (genIdle),
    .cmdValid(cmdValid),
    .cmdData (cmdData),
    .cmdReady(cmdReady),
    .cpuResN (cpuResN),
    .strobe  (strobe)
  );

  cpu_stepclk_datapath #(
    .PHASE_LEN(PHASE_LEN),
    .ADDR_W   (16),
    .DATA_W   (8),
    .FLAG_W   (4)
  ) dpI (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .cmdValid  (cmdValid),
    .busFlags  ({cpuVecPullN, cpuMemLockN, cpuSync, cpuRw}),
    .busAddr   (cpuAddr),
    .busData   (cpuData),
    .phi2      (cpuPhi2),
    .genIdle   (genIdle),
    .traceValid(traceValid),
    .traceFlags(traceFlags),
    .traceAddr (traceAddr),
    .traceData (traceData)
  );

endmodule

// File: rtl/cpu_stepclk_chk.sv
module cpu_stepclk_chk (
  input logic        clk,
  input logic        rstN,
  input logic        cmdReady,
  input logic        cpuPhi2,
  input logic        cpuResN,
  input logic        cpuRdy,
  input logic        cpuIrqN,
  input logic        cpuNmiN,
  input logic        cpuSoN,
  input logic        cpuBusEn,
  input logic [15:0] cpuAddr,
  input logic [7:0]  cpuData,
  input logic        traceValid,
  input logic [15:0] traceAddr,
  input logic [7:0]  traceData
);

  // R1
  res_edge_parked_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(cpuResN) |-> (!cpuPhi2 && !$past(cpuPhi2)));

  // R1
  res_no_trace_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cpuResN |-> !traceValid);

  // R2
  idle_lines_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    cpuRdy && cpuIrqN && cpuNmiN && cpuSoN && cpuBusEn);

  // R9
  trace_after_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    traceValid |-> (!cpuPhi2 && $past(cpuPhi2)));

  // R9
  trace_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    traceValid |-> (traceAddr == $past(cpuAddr) && traceData == $past(cpuData)));

  // R9
  trace_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    traceValid |=> !traceValid);

  // R11
  ready_parked_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdReady |-> (!cpuPhi2 && cpuResN));

endmodule

bind cpu_stepclk cpu_stepclk_chk chkI (.*);

// File: tb/cpu_stepclk_test.sv
module cpu_stepclk_test;

  localparam int P   = 2;
  localparam int RLO = 2;
  localparam int RHI = 7;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic [7:0]  cmdData = 8'h00;
  logic        cmdReady, cpuPhi2, cpuResN;
  logic        cpuRdy, cpuIrqN, cpuNmiN, cpuSoN, cpuBusEn;
  logic        cpuRw = 1'b1, cpuSync = 1'b0, cpuMemLockN = 1'b1, cpuVecPullN = 1'b1;
  logic [15:0] cpuAddr = 16'h0000;
  logic [7:0]  cpuData = 8'h00;
  logic        traceValid;
  logic [3:0]  traceFlags;
  logic [15:0] traceAddr;
  logic [7:0]  traceData;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  cpu_stepclk uut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdData(cmdData), .cmdReady(cmdReady),
    .cpuPhi2(cpuPhi2), .cpuResN(cpuResN), .cpuRdy(cpuRdy), .cpuIrqN(cpuIrqN),
    .cpuNmiN(cpuNmiN), .cpuSoN(cpuSoN), .cpuBusEn(cpuBusEn), .cpuRw(cpuRw),
    .cpuSync(cpuSync), .cpuMemLockN(cpuMemLockN), .cpuVecPullN(cpuVecPullN),
    .cpuAddr(cpuAddr), .cpuData(cpuData), .traceValid(traceValid),
    .traceFlags(traceFlags), .traceAddr(traceAddr), .traceData(traceData)
  );

  task automatic check(input string req, input string what, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // Behavioural reference: mode 0=reset low,1=reset high,2=step,3=run
  int mMode = 0, mDone = 0, mPos = 0, mWhy = 0;
  bit mBusy = 0, mHigh = 0, mBack = 0, mTv = 0;
  logic [15:0] mAddr = 0;
  logic [7:0]  mData = 0;
  logic [3:0]  mFlags = 0;
  bit wasIdle, launch;
  int launchWhy;

  always @(posedge clk) begin
    if (!rstN) begin
      mMode = 0; mDone = 0; mPos = 0; mWhy = 0;
      mBusy = 0; mHigh = 0; mBack = 0; mTv = 0;
    end else begin
      wasIdle = !mBusy; launch = 0; launchWhy = 0; mTv = 0;
      if (mBusy) begin
        if (mPos > 0) mPos--;
        else if (mHigh) begin
          mHigh = 0; mPos = P - 1;
          if (mWhy == 1 || (mWhy == 2 && cmdValid)) begin
            mTv = 1; mAddr = cpuAddr; mData = cpuData;
            mFlags = {cpuVecPullN, cpuMemLockN, cpuSync, cpuRw};
          end
        end else mBusy = 0;
      end
      if (wasIdle) begin
        if (mMode == 0 || mMode == 1) begin
          if (mDone == (mMode == 0 ? RLO : RHI)) begin
            mMode = (mMode == 0) ? 1 : (mBack ? 3 : 2);
            mDone = 0;
          end else begin
            launch = 1; mDone++;
          end
        end else if (cmdValid) begin
          if (cmdData == 8'h72) begin
            mBack = (mMode == 3); mMode = 0; mDone = 0;
          end else if (mMode == 2 && cmdData == 8'h73) begin
            launch = 1; launchWhy = 1;
          end else if (mMode == 2 && cmdData == 8'h63) mMode = 3;
          else if (mMode == 3 && cmdData == 8'h62) mMode = 2;
        end else if (mMode == 3) begin
          launch = 1; launchWhy = 2;
        end
      end
      if (launch) begin
        mBusy = 1; mHigh = 1; mPos = P - 1; mWhy = launchWhy;
      end
    end
  end

  // Bus stimulus: new values every clock
  initial begin
    int n = 0;
    forever begin
      @(negedge clk);
      n++;
      cpuAddr     = 16'(n * 16'h0137 + 16'h1000);
      cpuData     = 8'(n * 5 + 3);
      cpuRw       = n[0];
      cpuSync     = n[1];
      cpuMemLockN = ~n[2];
      cpuVecPullN = ~n[3];
    end
  end

  // Per-clock comparison and event counters
  int riseLo = 0, riseHi = 0, traces = 0;
  bit prevPhi = 0;
  always @(negedge clk) begin
    if (rstN) begin
      check("R4", "phi2", cpuPhi2, mHigh);
      check("R1", "resN", cpuResN, mMode != 0);
      check("R11", "cmdReady", cmdReady, (mMode >= 2) && !mBusy);
      check("R10", "traceValid", traceValid, mTv);
      check("R2", "idle lines", {cpuRdy, cpuIrqN, cpuNmiN, cpuSoN, cpuBusEn}, 5'h1f);
      if (mTv && traceValid) begin
        check("R9", "traceAddr", traceAddr, mAddr);
        check("R9", "traceData", traceData, mData);
        check("R9", "traceFlags", traceFlags, mFlags);
      end
      if (cpuPhi2 && !prevPhi) begin
        if (cpuResN) riseHi++; else riseLo++;
      end
      if (traceValid) traces++;
    end
    prevPhi = cpuPhi2;
  end

  task automatic sendCmd(input logic [7:0] b);
    @(negedge clk);
    cmdValid = 1'b1;
    cmdData  = b;
    while (!cmdReady) @(negedge clk);
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finishRun();
  end

  initial begin
    int lo0, hi0, tr0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 R11: reset state
    check("R1", "reset resN low", cpuResN, 0);
    check("R11", "reset ready low", cmdReady, 0);
    check("R1", "reset trace idle", traceValid, 0);
    idle(80);
    check("R1", "power-up low cycles", riseLo, RLO);
    check("R1", "power-up high cycles", riseHi, RHI);
    check("R1", "no trace in reset", traces, 0);
    // R3: parked in step mode
    hi0 = riseHi; idle(30);
    check("R3", "parked after power-up", riseHi, hi0);
    // R8: inapplicable bytes in step mode
    sendCmd(8'h62); sendCmd(8'h41); idle(20);
    check("R8", "step-mode discard", riseHi, hi0);
    // R4: steps
    for (int k = 0; k < 3; k++) begin
      hi0 = riseHi; tr0 = traces;
      sendCmd(8'h73); idle(10);
      check("R4", "one cycle per step", riseHi, hi0 + 1);
      check("R4", "one trace per step", traces, tr0 + 1);
    end
    // R7: reset from step mode returns to step mode
    lo0 = riseLo; hi0 = riseHi;
    sendCmd(8'h72); idle(80);
    check("R7", "step reset low cycles", riseLo, lo0 + RLO);
    check("R7", "step reset high cycles", riseHi, hi0 + RHI);
    hi0 = riseHi; idle(20);
    check("R7", "still step after reset", riseHi, hi0);
    // R5 R10: run mode without pending bytes
    tr0 = traces; hi0 = riseHi;
    sendCmd(8'h63); idle(50);
    check("R5", "free running", (riseHi - hi0) >= 9, 1);
    check("R10", "no trace while quiet", traces, tr0);
    // R8 R10: inapplicable bytes in run mode still trace while pending
    tr0 = traces;
    sendCmd(8'h73); sendCmd(8'h63);
    hi0 = riseHi; idle(30);
    check("R8", "run continues after discard", (riseHi - hi0) >= 5, 1);
    check("R10", "trace while byte pending", traces > tr0, 1);
    // R7: reset in run mode returns to run mode
    lo0 = riseLo;
    sendCmd(8'h72); idle(80);
    check("R7", "run reset low cycles", riseLo, lo0 + RLO);
    hi0 = riseHi; idle(20);
    check("R7", "running after reset", (riseHi - hi0) >= 4, 1);
    // R6: break
    sendCmd(8'h62); idle(8);
    hi0 = riseHi; idle(30);
    check("R6", "stopped after break", riseHi, hi0);
    hi0 = riseHi;
    sendCmd(8'h73); idle(10);
    check("R6", "step after break", riseHi, hi0 + 1);
    finishRun();
  end

endmodule